// File: doc/BRIEF.md
# Page-Table Entry Walker

This block runs after a translation cache misses. It takes a virtual page number and finds the physical page number by fetching one page-table entry from memory. The block holds two registers for the running process. The table origin register is a physical byte address. The table limit register is the highest page number that the table covers.

For each accepted walk, the block first compares the page number with the limit. A page number above the limit fails at once and never touches memory. Any other page number produces a word address, which is the origin plus four times the page number. The block issues one read for that address on a request/ready port and waits for the returned word. It then decodes the word. A resident page yields its frame number. A non-resident page yields a page-fault code together with the disk block number that the entry holds.

Only one walk is in flight at a time. The requester sees `req_ready` low from acceptance until the single-cycle result pulse has gone by.

Top module: `page_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` is 0, `mem_req` is 0, and both the origin and the limit registers hold 0.
- R2: A cycle with `cfg_load` high writes `cfg_base` into the origin and `cfg_limit` into the limit. A walk accepted in that same cycle uses the values held before the write. A walk already in progress is not affected by a load.
- R3: For a walk within the limit, `mem_addr` equals the origin plus `req_vpn` times 4, modulo 2^32.
- R4: When `req_vpn` is greater than the limit, the walk ends with `res_code` = 2 (bound fault), `res_page` = 0 and `res_entry` = 0. `res_valid` rises in the cycle right after acceptance, and no memory request is made.
- R5: A walk within the limit raises `mem_req` in the cycle after acceptance. `mem_req` and `mem_addr` stay steady until a cycle with `mem_ready` high. Exactly one read is made per walk.
- R6: The entry layout is: bit 0 is present, bit 1 is dirty, bit 2 is referenced, and bits 31:12 hold the frame number or the disk block number.
- R7: When the present bit is 1, the result has `res_code` = 0 (translated) and `res_page` = entry bits 31:12. `res_entry` is the entry with bit 2 forced to 1 and every other bit unchanged.
- R8: When the present bit is 0, the result has `res_code` = 1 (page fault), `res_page` = the disk block number in bits 31:12, and `res_entry` = the entry unchanged.
- R9: `req_ready` is low from the cycle after acceptance through the cycle in which `res_valid` is high. `res_valid` lasts exactly one cycle, and `req_ready` returns to 1 in the next cycle.
- R10: `res_valid` rises in the cycle right after the cycle in which `mem_rvalid` is sampled high while the walk waits for its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Write the origin and limit registers |
| cfg_base | input | 32 | New table origin (physical byte address) |
| cfg_limit | input | 20 | New highest valid page number |
| req_valid | input | 1 | Walk request |
| req_vpn | input | 20 | Virtual page number to resolve |
| req_ready | output | 1 | Walker idle; a request is taken in this cycle |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 32 | Byte address of the entry |
| mem_ready | input | 1 | Memory takes the read request |
| mem_rvalid | input | 1 | Entry data present |
| mem_rdata | input | 32 | Returned entry word |
| res_valid | output | 1 | Result pulse |
| res_code | output | 2 | 0 translated, 1 page fault, 2 bound fault |
| res_page | output | 20 | Frame number or disk block number |
| res_entry | output | 32 | Copy of the entry, with the referenced bit set when the page is present |

## Verification
A register load and a walk acceptance can fall in the same cycle. A load can also land while a walk waits on memory. The bench raises `cfg_load` at random, independently of `req_valid`, so both cases occur many times. The reference model computes the expected address and the expected limit decision from the register values it held before applying that cycle's load. Any entry address or fault code that reflects the new values is counted as a failure.

// File: rtl/pw_pkg.sv
package pw_pkg;

   typedef enum logic [1:0] {
      RES_XLATE   = 2'd0,
      RES_PGFAULT = 2'd1,
      RES_BOUND   = 2'd2
   } res_code_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_DONE  = 2'd3
   } walk_state_e;

   localparam int unsigned PTE_PRESENT_BIT = 0;
   localparam int unsigned PTE_DIRTY_BIT   = 1;
   localparam int unsigned PTE_REF_BIT     = 2;

endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
   parameter int unsigned VPN_W     = 20,
   parameter int unsigned PA_W      = 32,
   parameter int unsigned PTE_SHIFT = 2,
   parameter bit          BOUND_EN  = 1'b1
) (
   input  logic [VPN_W-1:0] vpn,
   input  logic [PA_W-1:0]  base,
   input  logic [VPN_W-1:0] limit,
   output logic [PA_W-1:0]  entry_addr,
   output logic             out_of_bound
);

   logic [PA_W-1:0] offset;

   assign offset     = PA_W'(vpn) << PTE_SHIFT;
   assign entry_addr = base + offset;

   generate
      if (BOUND_EN) begin : g_bound
         assign out_of_bound = (vpn > limit);
      end else begin : g_nobound
         logic unused_limit;
         assign unused_limit = ^limit;
         assign out_of_bound = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
   import pw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic out_of_bound,
   input  logic mem_ready,
   input  logic mem_rvalid,
   output logic req_ready,
   output logic mem_req,
   output logic res_valid,
   output logic take_walk,
   output logic take_bound,
   output logic take_entry
);

   walk_state_e state_q, state_d;

   assign req_ready  = (state_q == ST_IDLE);
   assign mem_req    = (state_q == ST_ISSUE);
   assign res_valid  = (state_q == ST_DONE);
   assign take_walk  = req_ready && req_valid && !out_of_bound;
   assign take_bound = req_ready && req_valid && out_of_bound;
   assign take_entry = (state_q == ST_WAIT) && mem_rvalid;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (take_bound)     state_d = ST_DONE;
            else if (take_walk) state_d = ST_ISSUE;
         end
         ST_ISSUE: if (mem_ready) state_d = ST_WAIT;
         ST_WAIT:  if (mem_rvalid) state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/pw_decode.sv
module pw_decode
   import pw_pkg::*;
#(
   parameter int unsigned PTE_W      = 32,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter bit          SET_REF    = 1'b1,
   localparam int unsigned FRAME_W   = PTE_W - PAGE_SHIFT
) (
   input  logic [PTE_W-1:0]   entry_in,
   output res_code_e          code,
   output logic [FRAME_W-1:0] page,
   output logic [PTE_W-1:0]   entry_out
);

   logic present;

   assign present = entry_in[PTE_PRESENT_BIT];
   assign page    = entry_in[PTE_W-1:PAGE_SHIFT];
   assign code    = present ? RES_XLATE : RES_PGFAULT;

   generate
      if (SET_REF) begin : g_mark_ref
         always_comb begin
            entry_out = entry_in;
            if (present) entry_out[PTE_REF_BIT] = 1'b1;
         end
      end else begin : g_plain
         assign entry_out = entry_in;
      end
   endgenerate

endmodule

// File: rtl/page_walker.sv
module page_walker
   import pw_pkg::*;
#(
   parameter int unsigned VA_W       = 32,
   parameter int unsigned PA_W       = 32,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned PTE_BYTES  = 4,
   parameter bit          BOUND_EN   = 1'b1,
   parameter bit          SET_REF    = 1'b1,
   localparam int unsigned PTE_W     = PTE_BYTES * 8,
   localparam int unsigned VPN_W     = VA_W - PAGE_SHIFT,
   localparam int unsigned FRAME_W   = PTE_W - PAGE_SHIFT,
   localparam int unsigned PTE_SHIFT = $clog2(PTE_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_load,
   input  logic [PA_W-1:0]    cfg_base,
   input  logic [VPN_W-1:0]   cfg_limit,
   input  logic               req_valid,
   input  logic [VPN_W-1:0]   req_vpn,
   output logic               req_ready,
   output logic               mem_req,
   output logic [PA_W-1:0]    mem_addr,
   input  logic               mem_ready,
   input  logic               mem_rvalid,
   input  logic [PTE_W-1:0]   mem_rdata,
   output logic               res_valid,
   output logic [1:0]         res_code,
   output logic [FRAME_W-1:0] res_page,
   output logic [PTE_W-1:0]   res_entry
);

   generate
      if (PTE_BYTES != (1 << PTE_SHIFT)) begin : g_bad_pte
         $error("PTE_BYTES must be a power of two");
      end
      if (VA_W <= PAGE_SHIFT) begin : g_bad_va
         $error("VA_W must exceed PAGE_SHIFT");
      end
      if (PTE_W <= PAGE_SHIFT || PAGE_SHIFT <= PTE_REF_BIT) begin : g_bad_fmt
         $error("entry must hold flag bits and a page field");
      end
   endgenerate

   logic [PA_W-1:0]    base_q;
   logic [VPN_W-1:0]   limit_q;
   logic [PA_W-1:0]    addr_q;
   logic [PA_W-1:0]    entry_addr;
   logic               out_of_bound;
   logic               take_walk, take_bound, take_entry;
   res_code_e          dec_code, code_q;
   logic [FRAME_W-1:0] dec_page, page_q;
   logic [PTE_W-1:0]   dec_entry, entry_q;

   pw_addr_gen #(
      .VPN_W(VPN_W), .PA_W(PA_W), .PTE_SHIFT(PTE_SHIFT), .BOUND_EN(BOUND_EN)
   ) u_addr (
      .vpn(req_vpn), .base(base_q), .limit(limit_q),
      .entry_addr(entry_addr), .out_of_bound(out_of_bound)
   );

   pw_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .out_of_bound(out_of_bound), .mem_ready(mem_ready),
      .mem_rvalid(mem_rvalid), .req_ready(req_ready), .mem_req(mem_req),
      .res_valid(res_valid), .take_walk(take_walk),
      .take_bound(take_bound), .take_entry(take_entry)
   );

   pw_decode #(
      .PTE_W(PTE_W), .PAGE_SHIFT(PAGE_SHIFT), .SET_REF(SET_REF)
   ) u_dec (
      .entry_in(mem_rdata), .code(dec_code), .page(dec_page),
      .entry_out(dec_entry)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         limit_q <= '0;
      end else if (cfg_load) begin
         base_q  <= cfg_base;
         limit_q <= cfg_limit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         addr_q <= '0;
      else if (take_walk) addr_q <= entry_addr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= RES_XLATE;
         page_q  <= '0;
         entry_q <= '0;
      end else if (take_bound) begin
         code_q  <= RES_BOUND;
         page_q  <= '0;
         entry_q <= '0;
      end else if (take_entry) begin
         code_q  <= dec_code;
         page_q  <= dec_page;
         entry_q <= dec_entry;
      end
   end

   assign mem_addr  = addr_q;
   assign res_code  = code_q;
   assign res_page  = page_q;
   assign res_entry = entry_q;

endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
   parameter int unsigned PA_W      = 32,
   parameter int unsigned VPN_W     = 20,
   parameter int unsigned PTE_W     = 32,
   parameter int unsigned FRAME_W   = 20,
   parameter int unsigned PTE_SHIFT = 2,
   parameter bit          BOUND_EN  = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [VPN_W-1:0]   req_vpn,
   input logic               req_ready,
   input logic               mem_req,
   input logic [PA_W-1:0]    mem_addr,
   input logic               mem_ready,
   input logic               mem_rvalid,
   input logic               res_valid,
   input logic [1:0]         res_code,
   input logic [FRAME_W-1:0] res_page,
   input logic [PTE_W-1:0]   res_entry,
   input logic [PA_W-1:0]    base_q,
   input logic [VPN_W-1:0]   limit_q
);

   AST_WALK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !(BOUND_EN && req_vpn > limit_q)) |=>
      (mem_req && mem_addr == $past(base_q + (PA_W'(req_vpn) << PTE_SHIFT)))); // R3

   AST_BOUND_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (BOUND_EN && req_valid && req_ready && req_vpn > limit_q) |=>
      (res_valid && !mem_req && res_code == 2'd2)); // R4

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R5

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R9

   AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> (!res_valid && req_ready)); // R9

   AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid && req_ready)); // R9

   AST_RES_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rvalid && !mem_req && !req_ready && !res_valid) |=> res_valid); // R10

   AST_REF_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == 2'd0) |-> (res_entry[2] && res_entry[0])); // R7

   AST_FAULT_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == 2'd1) |-> !res_entry[0]); // R8

   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_code != 2'd3)); // R6

endmodule

bind page_walker pw_checker #(
   .PA_W(PA_W), .VPN_W(VPN_W), .PTE_W(PTE_W), .FRAME_W(FRAME_W),
   .PTE_SHIFT(PTE_SHIFT), .BOUND_EN(BOUND_EN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
   .req_ready(req_ready), .mem_req(mem_req), .mem_addr(mem_addr),
   .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .res_valid(res_valid),
   .res_code(res_code), .res_page(res_page), .res_entry(res_entry),
   .base_q(base_q), .limit_q(limit_q)
);

// File: tb/page_walker_bench.sv
module page_walker_bench;

   localparam int STOP_CYC = 6000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic [31:0] cfg_base = '0;
   logic [19:0] cfg_limit = '0;
   logic        req_valid = 1'b0;
   logic [19:0] req_vpn = '0;
   logic        req_ready, mem_req, res_valid;
   logic [31:0] mem_addr, res_entry;
   logic        mem_ready = 1'b0, mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [1:0]  res_code;
   logic [19:0] res_page;

   page_walker u_page_walker (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
      .cfg_limit(cfg_limit), .req_valid(req_valid), .req_vpn(req_vpn),
      .req_ready(req_ready), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .res_valid(res_valid), .res_code(res_code), .res_page(res_page),
      .res_entry(res_entry)
   );

   always #2 clk = ~clk;

   int checks = 0, errors = 0;
   int cyc = 0, busy_cyc = 0, pend = 0, hs_cnt = 0;
   bit busy = 0, exp_res = 0, ex_bound = 0, started = 0;
   logic [31:0] m_base = '0, ex_addr = '0, ex_entry = '0;
   logic [19:0] m_limit = '0, ex_page = '0;
   logic [1:0]  ex_code = '0;

   function automatic logic [31:0] pte_of(logic [31:0] a);
      logic [31:0] h;
      h = a * 32'h9E37_79B1 + 32'h1234_5677;
      return {h[31:12], 9'b0, h[15:13]};
   endfunction

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      void'($urandom(7));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   end

   always @(negedge clk) begin
      logic [19:0] v;
      int r;
      if (rst_n) begin
         cyc++;
         if (!started) begin
            started = 1;
            check(req_ready === 1'b1, "R1 req_ready", req_ready, 1);
            check(res_valid === 1'b0, "R1 res_valid", res_valid, 0);
            check(mem_req === 1'b0, "R1 mem_req", mem_req, 0);
         end
         // result timing (R4, R10) and contents (R6, R7, R8)
         check(res_valid === exp_res, "R10 res_valid timing", res_valid, exp_res);
         if (res_valid) begin
            check(res_code === ex_code, "R7 R8 R4 res_code", res_code, ex_code);
            check(res_page === ex_page, "R6 res_page", res_page, ex_page);
            check(res_entry === ex_entry, "R7 R8 res_entry", res_entry, ex_entry);
            check(hs_cnt == (ex_bound ? 0 : 1), "R5 R4 read count", hs_cnt, ex_bound ? 0 : 1);
         end
         check(req_ready === !busy, "R9 req_ready", req_ready, !busy);
         if (mem_req) begin
            check(busy && !ex_bound, "R4 no read on bound fault", mem_req, 0);
            check(mem_addr === ex_addr, "R3 R2 entry address", mem_addr, ex_addr);
         end
         if (res_valid) busy = 0;
         exp_res = 0;
         busy_cyc = busy ? busy_cyc + 1 : 0;
         if (busy_cyc > 100 || cyc > 150000) begin
            check(0, "watchdog", busy_cyc, 0);
            finish_run();
         end

         // memory model
         mem_rvalid = 1'b0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               mem_rvalid = 1'b1;
               mem_rdata  = pte_of(ex_addr);
               exp_res    = 1;
            end
         end else if ($urandom % 4 == 0) begin
            mem_rvalid = 1'b1;          // stray pulse while not waiting
            mem_rdata  = $urandom;
            if (busy && !mem_req && !ex_bound && hs_cnt == 1) begin
               mem_rvalid = 1'b0;      // never fake data for a live walk
            end
         end
         mem_ready = ($urandom % 2) == 0;
         if (mem_req && mem_ready) begin
            hs_cnt++;
            pend = 1 + ($urandom % 3);
         end

         // request stimulus
         r = $urandom % 8;
         if (r < 2) v = m_limit;
         else if (r == 2) v = m_limit + 20'd1;
         else if (r == 3) v = 20'd0;
         else v = 20'($urandom % 300);
         req_vpn   = v;
         req_valid = (cyc < STOP_CYC) && ($urandom % 2 == 0);
         if (req_valid && req_ready && !busy) begin
            busy = 1;
            hs_cnt = 0;
            if (v > m_limit) begin
               ex_bound = 1;
               ex_code  = 2'd2;
               ex_page  = '0;
               ex_entry = '0;
               exp_res  = 1;
            end else begin
               ex_bound = 0;
               ex_addr  = m_base + {10'b0, v, 2'b00};
               ex_entry = pte_of(ex_addr);
               ex_page  = ex_entry[31:12];
               if (ex_entry[0]) begin
                  ex_code  = 2'd0;
                  ex_entry = ex_entry | 32'h4;
               end else begin
                  ex_code = 2'd1;
               end
            end
         end

         // register loads, checked as R2 through later walks
         cfg_load = (cyc > 40) && ($urandom % 12 == 0);
         if (cfg_load) begin
            cfg_base  = $urandom;
            cfg_limit = ($urandom % 10 == 0) ? 20'hFFFFF : 20'($urandom % 256);
            m_base  = cfg_base;
            m_limit = cfg_limit;
         end

         if (cyc >= STOP_CYC && !busy) finish_run();
      end
   end

endmodule